// File: doc/BRIEF.md
# Program Flow Controller with Profiling Counter

This unit owns the 16-bit program counter of a small DSP core. Every clock cycle an operation code from the decoder tells it whether to keep the PC, step it by one, jump to an absolute immediate, jump by a signed 8-bit offset, jump to a register-file operand, or take a relative branch on equal or not-equal, judged by the ALU zero flag. The current PC is driven straight out as the program memory address.

Next to the PC logic sits a 32-bit event counter for profiling. Software picks what it counts with a mode operation: nothing, every taken jump or branch, conditional branches that are taken, conditional branches that fall through, or cycles in which the PC is held. Software reads the counter in two 16-bit halves through a registered return path to the register file, and loads it the same way.

Top module: `pfc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0xFFF0, the counter becomes 0, the mode becomes 0 and `to_rf_o` becomes 0.
- R2: Opcode 0 (hold) leaves the PC unchanged; opcode 1 (step) and the unused opcodes 12 to 15 set PC to PC+1 modulo 2^16.
- R3: Opcode 2 sets PC to `imm_i`; opcode 4 sets PC to `rf_i`.
- R4: Opcode 3 sets PC to PC plus `imm_i[7:0]` sign-extended, modulo 2^16.
- R5: Opcode 5 branches (PC plus sign-extended `imm_i[7:0]`) when `flag_z` is 1, opcode 6 when `flag_z` is 0; otherwise PC+1. `flag_n`, `flag_v` and `flag_c` have no effect.
- R6: Opcode 7 loads the mode from `rf_i[2:0]`, effective from the next cycle; opcodes 7 to 11 all set PC to PC+1.
- R7: Opcode 8 places counter bits 31:16, opcode 9 bits 15:0, on `to_rf_o` one cycle later; `to_rf_o` keeps its value under every other opcode.
- R8: Opcode 10 loads counter bits 31:16 and opcode 11 bits 15:0 from `rf_i`, leaving the other half untouched; a loaded half wins over any increment in that cycle.
- R9: In mode 1 the counter increments once for each opcode 2, 3 or 4, and for each opcode 5 or 6 whose condition holds.
- R10: Mode 2 increments on opcode 5 or 6 with the condition true; mode 3 on opcode 5 or 6 with the condition false.
- R11: Mode 4 increments once for every opcode 0 cycle.
- R12: Mode 0 and modes 5 to 7 never increment; the counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| flag_z | input | 1 | ALU zero flag |
| flag_n | input | 1 | ALU negative flag (no effect) |
| flag_v | input | 1 | ALU overflow flag (no effect) |
| flag_c | input | 1 | ALU carry flag (no effect) |
| rf_i | input | 16 | Register-file operand |
| imm_i | input | 16 | Immediate from the instruction word |
| pm_addr_o | output | 16 | Program memory address, the current PC |
| to_rf_o | output | 16 | Registered counter half for the register file |

## Verification
The PC update and the counter increment land in the same cycle whenever a jump, branch or hold is issued in a counting mode, so the sweep issues every opcode with both values of the zero flag under each of the eight mode values and then reads both counter halves, comparing them with a count derived in the bench from the mode rules while the PC is compared after every single step. A second collision, a counter half load meeting the wrap of the increment, is provoked by loading 0xFFFFFFFF and taking a jump, then loading a half while in the stall mode and reading both halves back.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [3:0] {
    OP_HOLD    = 4'd0,
    OP_STEP    = 4'd1,
    OP_JABS    = 4'd2,
    OP_JREL    = 4'd3,
    OP_JREG    = 4'd4,
    OP_BEQ     = 4'd5,
    OP_BNE     = 4'd6,
    OP_SETMODE = 4'd7,
    OP_RDHI    = 4'd8,
    OP_RDLO    = 4'd9,
    OP_WRHI    = 4'd10,
    OP_WRLO    = 4'd11
  } pfc_op_e;

  typedef enum logic [2:0] {
    CM_OFF    = 3'd0,
    CM_TAKEN  = 3'd1,
    CM_CTRUE  = 3'd2,
    CM_CFALSE = 3'd3,
    CM_STALL  = 3'd4
  } cnt_mode_e;

  // events raised by the PC logic for the counter
  typedef struct packed {
    logic taken;
    logic cond_true;
    logic cond_false;
    logic stalled;
  } pfc_evt_t;

endpackage

// File: rtl/pfc_next_pc.sv
module pfc_next_pc
  import pfc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFS_W = 8
) (
  input  logic [PC_W-1:0] pc,
  input  logic [3:0]      op,
  input  logic            zero,
  input  logic [PC_W-1:0] imm,
  input  logic [PC_W-1:0] rf,
  output logic [PC_W-1:0] nxt,
  output pfc_evt_t        evt
);

  localparam int EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_rel;
  logic [PC_W-1:0] ofs_ext;
  logic            is_cond;
  logic            cond_ok;

  assign ofs_ext = {{EXT_W{imm[OFS_W-1]}}, imm[OFS_W-1:0]};
  assign pc_inc  = pc + {{(PC_W-1){1'b0}}, 1'b1};
  assign pc_rel  = pc + ofs_ext;

  always_comb begin
    is_cond = 1'b0;
    cond_ok = 1'b0;
    case (op)
      OP_BEQ: begin is_cond = 1'b1; cond_ok = zero;  end
      OP_BNE: begin is_cond = 1'b1; cond_ok = ~zero; end
      default: ;
    endcase
  end

  always_comb begin
    nxt       = pc_inc;
    evt       = '0;
    case (op)
      OP_HOLD: begin
        nxt         = pc;
        evt.stalled = 1'b1;
      end
      OP_JABS: begin
        nxt       = imm;
        evt.taken = 1'b1;
      end
      OP_JREL: begin
        nxt       = pc_rel;
        evt.taken = 1'b1;
      end
      OP_JREG: begin
        nxt       = rf;
        evt.taken = 1'b1;
      end
      OP_BEQ, OP_BNE: begin
        nxt = cond_ok ? pc_rel : pc_inc;
      end
      default: nxt = pc_inc;
    endcase
    if (is_cond) begin
      evt.taken      = cond_ok;
      evt.cond_true  = cond_ok;
      evt.cond_false = ~cond_ok;
    end
  end

endmodule

// File: rtl/pfc_perf_ctr.sv
module pfc_perf_ctr
  import pfc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic [CNT_W/2-1:0] wr_data,
  input  pfc_evt_t          evt,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W/2-1:0] rd_o
);

  localparam int HALF_W = CNT_W / 2;
  localparam int NHALF  = 2;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;
  logic [MODE_W-1:0] mode_q;
  logic [HALF_W-1:0] rd_q;
  logic              hit;

  // event selection by mode; unlisted modes count nothing
  always_comb begin
    case (mode_q)
      MODE_W'(CM_TAKEN):  hit = evt.taken;
      MODE_W'(CM_CTRUE):  hit = evt.cond_true;
      MODE_W'(CM_CFALSE): hit = evt.cond_false;
      MODE_W'(CM_STALL):  hit = evt.stalled;
      default:            hit = 1'b0;
    endcase
  end

  assign cnt_inc = cnt_q + {{(CNT_W-1){1'b0}}, hit};

  // one register slice per half; a software load of a half overrides the increment
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic wr_sel;
    if (h == 0) begin : g_lo
      assign wr_sel = (op == OP_WRLO);
    end else begin : g_hi
      assign wr_sel = (op == OP_WRHI);
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[h*HALF_W +: HALF_W] <= '0;
      end else if (wr_sel) begin
        cnt_q[h*HALF_W +: HALF_W] <= wr_data;
      end else begin
        cnt_q[h*HALF_W +: HALF_W] <= cnt_inc[h*HALF_W +: HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (op == OP_SETMODE) begin
      mode_q <= wr_data[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (op == OP_RDHI) begin
      rd_q <= cnt_q[CNT_W-1:HALF_W];
    end else if (op == OP_RDLO) begin
      rd_q <= cnt_q[HALF_W-1:0];
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign rd_o   = rd_q;

endmodule

// File: rtl/pfc_unit.sv
module pfc_unit
  import pfc_pkg::*;
#(
  parameter int              PC_W   = 16,
  parameter int              OFS_W  = 8,
  parameter int              CNT_W  = 32,
  parameter int              MODE_W = 3,
  parameter logic [PC_W-1:0] RST_PC = 16'hFFF0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3:0]      op_i,
  input  logic            flag_z,
  input  logic            flag_n,
  input  logic            flag_v,
  input  logic            flag_c,
  input  logic [PC_W-1:0] rf_i,
  input  logic [PC_W-1:0] imm_i,
  output logic [PC_W-1:0] pm_addr_o,
  output logic [PC_W-1:0] to_rf_o
);

  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_d;
  pfc_evt_t          evt_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [MODE_W-1:0] mode_w;
  logic              unused_flags;

  assign unused_flags = ^{flag_n, flag_v, flag_c};

  pfc_next_pc #(
    .PC_W  (PC_W),
    .OFS_W (OFS_W)
  ) u_next (
    .pc   (pc_q),
    .op   (op_i),
    .zero (flag_z),
    .imm  (imm_i),
    .rf   (rf_i),
    .nxt  (pc_d),
    .evt  (evt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RST_PC;
    else     pc_q <= pc_d;
  end

  pfc_perf_ctr #(
    .CNT_W  (CNT_W),
    .MODE_W (MODE_W)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .op      (op_i),
    .wr_data (rf_i),
    .evt     (evt_w),
    .cnt_o   (cnt_w),
    .mode_o  (mode_w),
    .rd_o    (to_rf_o)
  );

  assign pm_addr_o = pc_q;

endmodule

// File: rtl/pfc_unit_chk.sv
module pfc_unit_chk #(
  parameter int PC_W   = 16,
  parameter int CNT_W  = 32,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic              flag_z,
  input logic [PC_W-1:0]   rf_i,
  input logic [PC_W-1:0]   imm_i,
  input logic [PC_W-1:0]   pm_addr_o,
  input logic [PC_W-1:0]   to_rf_o,
  input logic [CNT_W-1:0]  cnt,
  input logic [MODE_W-1:0] mode
);

  localparam int HALF_W = CNT_W / 2;
  logic rst_seen = 1'b0;

  // R1: one edge after reset the PC holds its start value
  always @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen) begin
      p_reset_pc_r1: assert (pm_addr_o == 16'hFFF0)
        else $error("reset PC wrong");
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd0 |=> $stable(pm_addr_o));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd1 |=> pm_addr_o == $past(pm_addr_o) + 16'd1);

  p_jabs_r3: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd2 |=> pm_addr_o == $past(imm_i));

  p_jreg_r3: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd4 |=> pm_addr_o == $past(rf_i));

  p_bne_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd6 && flag_z) |=> pm_addr_o == $past(pm_addr_o) + 16'd1);

  p_rdlo_r7: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd9 |=> to_rf_o == $past(cnt[HALF_W-1:0]));

  p_rd_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i != 4'd8 && op_i != 4'd9) |=> $stable(to_rf_o));

  p_wrlo_r8: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd11 |=> cnt[HALF_W-1:0] == $past(rf_i) && cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W]));

  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd0 || mode > 3'd4) && op_i != 4'd10 && op_i != 4'd11) |=> $stable(cnt));

endmodule

bind pfc_unit pfc_unit_chk #(
  .PC_W   (PC_W),
  .CNT_W  (CNT_W),
  .MODE_W (MODE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .flag_z    (flag_z),
  .rf_i      (rf_i),
  .imm_i     (imm_i),
  .pm_addr_o (pm_addr_o),
  .to_rf_o   (to_rf_o),
  .cnt       (cnt_w),
  .mode      (mode_w)
);

// File: tb/pfc_unit_bench.sv
module pfc_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'd1;
  logic        flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0, flag_c = 1'b0;
  logic [15:0] rf_i = '0, imm_i = '0;
  logic [15:0] pm_addr_o, to_rf_o;

  int total = 0;
  int bad   = 0;

  // bench reference state
  logic [15:0] m_pc;
  logic [31:0] m_cnt;
  logic [2:0]  m_mode;
  logic [15:0] m_rd;

  always #10 clk = ~clk;  // 50 MHz

  pfc_unit u_pfc_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_c(flag_c), .rf_i(rf_i), .imm_i(imm_i),
    .pm_addr_o(pm_addr_o), .to_rf_o(to_rf_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R2";
      4'd2, 4'd4:       return "R3";
      4'd3:             return "R4";
      4'd5, 4'd6:       return "R5";
      4'd7:             return "R6";
      4'd8, 4'd9:       return "R7";
      4'd10, 4'd11:     return "R8";
      default:          return "R2";
    endcase
  endfunction

  // one operation: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [3:0] op, input logic [15:0] rf, input logic [15:0] imm, input logic z);
    logic [15:0] rel, nxt;
    logic        cond, taken, ctrue, cfalse, held, hit;
    op_i = op; rf_i = rf; imm_i = imm; flag_z = z;
    flag_n = 1'($urandom); flag_v = 1'($urandom); flag_c = 1'($urandom);
    @(posedge clk);
    rel = m_pc + {{8{imm[7]}}, imm[7:0]};
    nxt = m_pc + 16'd1;
    taken = 0; ctrue = 0; cfalse = 0; held = 0;
    case (op)
      4'd0: begin nxt = m_pc; held = 1; end
      4'd2: begin nxt = imm; taken = 1; end
      4'd3: begin nxt = rel; taken = 1; end
      4'd4: begin nxt = rf;  taken = 1; end
      4'd5, 4'd6: begin
        cond = (op == 4'd5) ? z : !z;
        if (cond) begin nxt = rel; taken = 1; ctrue = 1; end
        else cfalse = 1;
      end
      default: ;
    endcase
    case (m_mode)
      3'd1: hit = taken;
      3'd2: hit = ctrue;
      3'd3: hit = cfalse;
      3'd4: hit = held;
      default: hit = 0;
    endcase
    if (op == 4'd8) m_rd = m_cnt[31:16];
    if (op == 4'd9) m_rd = m_cnt[15:0];
    if (op == 4'd7) m_mode = rf[2:0];
    if (op == 4'd10)      m_cnt = {rf, m_cnt[15:0] + {15'd0, hit}};
    else if (op == 4'd11) m_cnt = {m_cnt[31:16] + {15'd0, (m_cnt[15:0] == 16'hFFFF) && hit}, rf};
    else                  m_cnt = m_cnt + {31'd0, hit};
    m_pc = nxt;
    @(negedge clk);
    chk(req_of(op), "pc", {16'd0, pm_addr_o}, {16'd0, m_pc});
    chk("R7", "to_rf", {16'd0, to_rf_o}, {16'd0, m_rd});
  endtask

  // read both halves and compare the combined counter
  task automatic read_cnt(input string req, input logic [31:0] exp);
    logic [15:0] hi;
    step(4'd8, '0, '0, 1'b0);
    hi = to_rf_o;
    step(4'd9, '0, '0, 1'b0);
    chk(req, "counter", {hi, to_rf_o}, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pc = 16'hFFF0; m_cnt = '0; m_mode = '0; m_rd = '0;
    // R1 reset state
    chk("R1", "reset pc", {16'd0, pm_addr_o}, 32'h0000FFF0);
    chk("R1", "reset to_rf", {16'd0, to_rf_o}, 32'd0);
    step(4'd0, '0, '0, 1'b0);  // mode 0 after reset must not count a hold
    read_cnt("R1", 32'd0);

    // sweep all modes, every opcode, both zero-flag values
    for (int md = 0; md < 8; md++) begin
      step(4'd7, 16'(md), '0, 1'b0);
      step(4'd10, 16'd0, '0, 1'b0);
      step(4'd11, 16'd0, '0, 1'b0);
      for (int op = 0; op < 16; op++) begin
        for (int z = 0; z < 2; z++) begin
          if (op == 7 || op == 10 || op == 11) continue;
          step(4'(op), 16'($urandom), 16'($urandom), 1'(z));
        end
      end
      case (md)
        1:       read_cnt("R9",  m_cnt);
        2, 3:    read_cnt("R10", m_cnt);
        4:       read_cnt("R11", m_cnt);
        default: read_cnt("R12", m_cnt);
      endcase
    end

    // explicit counts per mode with known sequences
    step(4'd7, 16'd1, '0, 1'b0); step(4'd10, 16'd0, '0, 1'b0); step(4'd11, 16'd0, '0, 1'b0);
    step(4'd2, 16'd0, 16'h0100, 1'b0); step(4'd5, 16'd0, 16'h0004, 1'b1); step(4'd6, 16'd0, 16'h0004, 1'b1);
    step(4'd0, 16'd0, 16'd0, 1'b0);
    read_cnt("R9", 32'd2);
    step(4'd7, 16'd3, '0, 1'b0); step(4'd11, 16'd0, '0, 1'b0);
    step(4'd5, 16'd0, 16'h00FE, 1'b0); step(4'd6, 16'd0, 16'h00FE, 1'b1); step(4'd5, 16'd0, 16'h00FE, 1'b1);
    read_cnt("R10", 32'd2);
    step(4'd7, 16'd4, '0, 1'b0); step(4'd11, 16'd0, '0, 1'b0);
    for (int k = 0; k < 5; k++) step(4'd0, '0, '0, 1'b0);
    read_cnt("R11", 32'd5);
    // R8: half load wins over a counted hold-free op; other half kept
    step(4'd10, 16'hA5A5, '0, 1'b0);
    read_cnt("R8", 32'hA5A5_0005);
    // R12: wrap from all ones
    step(4'd7, 16'd1, '0, 1'b0);
    step(4'd10, 16'hFFFF, '0, 1'b0); step(4'd11, 16'hFFFF, '0, 1'b0);
    step(4'd3, '0, 16'h0010, 1'b0);
    read_cnt("R12", 32'd0);
    // R4: relative wrap below zero
    step(4'd2, '0, 16'h0002, 1'b0);
    step(4'd3, '0, 16'h00F0, 1'b0);
    chk("R4", "rel wrap", {16'd0, pm_addr_o}, 32'h0000FFF2);
    // R6: mode 7 behaves as off
    step(4'd7, 16'hFFFF, '0, 1'b0); step(4'd11, 16'd0, '0, 1'b0); step(4'd10, 16'd0, '0, 1'b0);
    step(4'd0, '0, '0, 1'b0); step(4'd2, '0, 16'h1234, 1'b0);
    read_cnt("R6", 32'd0);

    // random sequence
    for (int k = 0; k < 2000; k++)
      step(4'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));
    read_cnt("R9", m_cnt);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule